// File: doc/BRIEF.md
# DMA Page Translation Map

This block translates the virtual addresses produced by an I/O adapter's DMA engine into physical memory addresses. The virtual transfer space is 17 bits wide and is cut into 512-byte pages. Each of the 256 pages has one map entry. An entry holds a valid flag and a 21-bit page frame number. Software loads and inspects the entries through a small register port. The DMA engine presents a virtual address on a lookup port and receives a hit flag and a 30-bit physical address one cycle later.

Every lookup records the entry it used in a read-only selected-entry register, whether that entry was valid or not. Software can read this register back to see which mapping a failing transfer hit. A lookup that lands on an invalid entry returns a miss. In the same cycle it raises a one-cycle invalid-map error pulse, which the surrounding adapter treats as an abort-class error. A synchronous adapter-init input clears the selected-entry register and leaves the map alone. Only the power-up reset clears the map contents.

Top module: `dma_page_xlate`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, rspValid, invMapErr and regRvalid are 0. After reset, every map entry and the selected-entry register read as 0.
- R2: A register write with regSel=0 stores only word bit 31 (valid flag) and bits [20:0] (page frame number) into entry regIdx. A read with regSel=0 returns those bits with all other bits 0. regRvalid and regRdata appear in the cycle after regRd.
- R3: A lookup (lkValid=1, adapterInit=0) uses entry lkVa[16:9]. In the next cycle it gives rspValid=1 for one cycle, with rspHit equal to the entry's valid flag. On a hit, rspPa = {frame number, lkVa[8:0]}.
- R4: A lookup of an invalid entry gives rspHit=0 and rspPa=0. invMapErr is 1 in exactly that response cycle and at no other time.
- R5: Every lookup, hit or miss, copies the entry it used into the selected-entry register. A read with regSel=1 returns this register in the same layout as a map read. A read issued in the same cycle as a lookup returns the earlier value.
- R6: A lookup in the same cycle as a map write to the same entry translates with the old contents and records the old contents. The next lookup sees the new contents.
- R7: A map read in the same cycle as a map write to the same entry returns the old contents.
- R8: adapterInit clears the selected-entry register at the next edge and does not change map contents. A lookup presented in the same cycle is dropped: no response and no error.
- R9: A register write with regSel=1 has no effect on the selected-entry register or on any map entry.
- R10: Lookups on consecutive cycles each produce their own response on consecutive cycles.
- R11: Only the power-up reset (rstN low) clears the map entries.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low power-up reset; clears map and all state |
| adapterInit | input | 1 | Synchronous adapter init; clears selected-entry register |
| lkValid | input | 1 | Lookup request strobe |
| lkVa | input | 17 | Virtual address to translate |
| rspValid | output | 1 | Lookup response strobe, one cycle after request |
| rspHit | output | 1 | Entry used was valid |
| rspPa | output | 30 | Physical address (0 on a miss) |
| invMapErr | output | 1 | One-cycle invalid-map error pulse |
| regRd | input | 1 | Register read strobe |
| regWr | input | 1 | Register write strobe |
| regSel | input | 1 | 0 selects map entry regIdx, 1 selects the selected-entry register |
| regIdx | input | 8 | Map entry index |
| regWdata | input | 32 | Register write data |
| regRvalid | output | 1 | Read data strobe, one cycle after regRd |
| regRdata | output | 32 | Read data |

## Verification
Each result is due exactly one clock edge after the cycle that asks for it. A lookup response and its error pulse follow lkValid by one edge, and read data follows regRd by one edge. State changes (a map write, a selected-entry capture, an init clear) are visible to any request made in a later cycle, but not to one made in the same cycle. The bench keeps a behavioural model that moves one cycle at a time. It drives each stimulus just after a falling edge and compares the outputs of the previous stimulus at the next falling edge, so every compare lands on the cycle in which a result is due. Same-cycle collisions are driven on purpose to pin down which of the old and new contents is returned.

// File: rtl/xlate_pkg.sv
package xlate_pkg;

  // Per-cycle commands from control to datapath.
  typedef struct packed {
    logic lookup;  // translate lkVa and capture the entry used
    logic mapWr;   // store regWdata into entry regIdx
    logic mapRd;   // load entry regIdx into read data
    logic smrRd;   // load selected-entry register into read data
    logic init;    // clear selected-entry register
  } xlateStrobe_t;

endpackage

// File: rtl/xlate_ctrl.sv
module xlate_ctrl
  import xlate_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         adapterInit,
  input  logic         lkValid,
  input  logic         regRd,
  input  logic         regWr,
  input  logic         regSel,
  output xlateStrobe_t strb,
  output logic         rspValidQ,
  output logic         rdValidQ
);

  // Init has priority over a lookup in the same cycle; a write to the
  // selected-entry register is decoded to nothing.
  always_comb begin
    strb        = '0;
    strb.init   = adapterInit;
    strb.lookup = lkValid & ~adapterInit;
    strb.mapWr  = regWr & ~regSel;
    strb.mapRd  = regRd & ~regSel;
    strb.smrRd  = regRd & regSel;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValidQ <= 1'b0;
      rdValidQ  <= 1'b0;
    end else begin
      rspValidQ <= strb.lookup;
      rdValidQ  <= regRd;
    end
  end

endmodule

// File: rtl/xlate_dpath.sv
module xlate_dpath
  import xlate_pkg::*;
#(
  parameter int VA_W      = 17,
  parameter int PAGE_BITS = 9,
  parameter int PFN_W     = 21,
  parameter int DATA_W    = 32,
  parameter int VALID_BIT = 31,
  localparam int IDX_W    = VA_W - PAGE_BITS,
  localparam int ENTRIES  = 1 << IDX_W,
  localparam int ENT_W    = PFN_W + 1,
  localparam int PA_W     = PFN_W + PAGE_BITS
) (
  input  logic              clk,
  input  logic              rstN,
  input  xlateStrobe_t      strb,
  input  logic [VA_W-1:0]   lkVa,
  input  logic [IDX_W-1:0]  regIdx,
  input  logic [DATA_W-1:0] regWdata,
  output logic              rspHit,
  output logic [PA_W-1:0]   rspPa,
  output logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] smrWord
);

  // Compact entry: valid flag at the top, frame number below.
  logic [ENT_W-1:0] mapQ [ENTRIES];
  logic [ENT_W-1:0] smrQ;
  logic [ENT_W-1:0] lkEnt;
  logic [ENT_W-1:0] rdEnt;
  logic [IDX_W-1:0] lkIdx;
  logic [ENT_W-1:0] wrEnt;

  function automatic logic [DATA_W-1:0] toWord(input logic [ENT_W-1:0] ent);
    logic [DATA_W-1:0] w;
    w                = '0;
    w[VALID_BIT]     = ent[PFN_W];
    w[PFN_W-1:0]     = ent[PFN_W-1:0];
    return w;
  endfunction

  assign lkIdx   = lkVa[VA_W-1:PAGE_BITS];
  assign lkEnt   = mapQ[lkIdx];
  assign rdEnt   = mapQ[regIdx];
  assign wrEnt   = {regWdata[VALID_BIT], regWdata[PFN_W-1:0]};
  assign smrWord = toWord(smrQ);

  // Map storage: cleared only by power-up reset.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int e = 0; e < ENTRIES; e++) mapQ[e] <= '0;
    end else if (strb.mapWr) begin
      mapQ[regIdx] <= wrEnt;
    end
  end

  // Selected-entry register.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            smrQ <= '0;
    else if (strb.init)   smrQ <= '0;
    else if (strb.lookup) smrQ <= lkEnt;
  end

  // Lookup result register.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspHit <= 1'b0;
      rspPa  <= '0;
    end else if (strb.lookup) begin
      rspHit <= lkEnt[PFN_W];
      rspPa  <= lkEnt[PFN_W] ? {lkEnt[PFN_W-1:0], lkVa[PAGE_BITS-1:0]} : '0;
    end
  end

  // Register read data.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           rdData <= '0;
    else if (strb.mapRd) rdData <= toWord(rdEnt);
    else if (strb.smrRd) rdData <= smrWord;
  end

endmodule

// File: rtl/dma_page_xlate.sv
module dma_page_xlate
  import xlate_pkg::*;
#(
  parameter int VA_W      = 17,
  parameter int PAGE_BITS = 9,
  parameter int PFN_W     = 21,
  parameter int DATA_W    = 32,
  parameter int VALID_BIT = 31,
  localparam int IDX_W    = VA_W - PAGE_BITS,
  localparam int PA_W     = PFN_W + PAGE_BITS
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              adapterInit,
  input  logic              lkValid,
  input  logic [VA_W-1:0]   lkVa,
  output logic              rspValid,
  output logic              rspHit,
  output logic [PA_W-1:0]   rspPa,
  output logic              invMapErr,
  input  logic              regRd,
  input  logic              regWr,
  input  logic              regSel,
  input  logic [IDX_W-1:0]  regIdx,
  input  logic [DATA_W-1:0] regWdata,
  output logic              regRvalid,
  output logic [DATA_W-1:0] regRdata
);

  xlateStrobe_t      strb;
  logic [DATA_W-1:0] smrWord;

  xlate_ctrl ctrl_i (
    .clk         (clk),
    .rstN        (rstN),
    .adapterInit (adapterInit),
    .lkValid     (lkValid),
    .regRd       (regRd),
    .regWr       (regWr),
    .regSel      (regSel),
    .strb        (strb),
    .rspValidQ   (rspValid),
    .rdValidQ    (regRvalid)
  );

  xlate_dpath #(
    .VA_W      (VA_W),
    .PAGE_BITS (PAGE_BITS),
    .PFN_W     (PFN_W),
    .DATA_W    (DATA_W),
    .VALID_BIT (VALID_BIT)
  ) dpath_i (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .lkVa     (lkVa),
    .regIdx   (regIdx),
    .regWdata (regWdata),
    .rspHit   (rspHit),
    .rspPa    (rspPa),
    .rdData   (regRdata),
    .smrWord  (smrWord)
  );

  assign invMapErr = rspValid & ~rspHit;

endmodule

// File: rtl/xlate_checker.sv
module xlate_checker #(
  parameter int DATA_W    = 32,
  parameter int VALID_BIT = 31
) (
  input logic              clk,
  input logic              rstN,
  input logic              adapterInit,
  input logic              lkValid,
  input logic              regRd,
  input logic              rspValid,
  input logic              rspHit,
  input logic              invMapErr,
  input logic              regRvalid,
  input logic [DATA_W-1:0] smrWord
);

  a_r3_rsp_follows_req: assert property (@(posedge clk) disable iff (!rstN)
    (lkValid && !adapterInit) |=> rspValid);

  a_r3_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rstN)
    !(lkValid && !adapterInit) |=> !rspValid);

  a_r4_err_on_miss_only: assert property (@(posedge clk) disable iff (!rstN)
    invMapErr |-> (rspValid && !rspHit));

  a_r4_miss_raises_err: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspHit) |-> invMapErr);

  a_r2_read_latency: assert property (@(posedge clk) disable iff (!rstN)
    regRd |=> regRvalid);

  a_r2_no_spurious_read: assert property (@(posedge clk) disable iff (!rstN)
    !regRd |=> !regRvalid);

  a_r5_smr_tracks_hit: assert property (@(posedge clk) disable iff (!rstN)
    (lkValid && !adapterInit) |=> (smrWord[VALID_BIT] == rspHit));

  a_r8_init_clears_smr: assert property (@(posedge clk) disable iff (!rstN)
    adapterInit |=> (smrWord == '0));

endmodule

bind dma_page_xlate xlate_checker #(
  .DATA_W    (32),
  .VALID_BIT (31)
) chk_i (
  .clk         (clk),
  .rstN        (rstN),
  .adapterInit (adapterInit),
  .lkValid     (lkValid),
  .regRd       (regRd),
  .rspValid    (rspValid),
  .rspHit      (rspHit),
  .invMapErr   (invMapErr),
  .regRvalid   (regRvalid),
  .smrWord     (smrWord)
);

// File: tb/dma_page_xlate_tb_top.sv
`timescale 1ns/1ps
module dma_page_xlate_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        adapterInit = 1'b0;
  logic        lkValid = 1'b0;
  logic [16:0] lkVa = '0;
  logic        rspValid, rspHit, invMapErr, regRvalid;
  logic [29:0] rspPa;
  logic        regRd = 1'b0, regWr = 1'b0, regSel = 1'b0;
  logic [7:0]  regIdx = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;

  always #5 clk = ~clk;

  dma_page_xlate dut_i (
    .clk(clk), .rstN(rstN), .adapterInit(adapterInit),
    .lkValid(lkValid), .lkVa(lkVa),
    .rspValid(rspValid), .rspHit(rspHit), .rspPa(rspPa), .invMapErr(invMapErr),
    .regRd(regRd), .regWr(regWr), .regSel(regSel), .regIdx(regIdx),
    .regWdata(regWdata), .regRvalid(regRvalid), .regRdata(regRdata)
  );

  localparam logic [31:0] KEEP = 32'h801F_FFFF;

  // Behavioural reference model
  logic [31:0] mapM [256];
  logic [31:0] smrM;
  logic        eRspV, eHit, eErr, eRv;
  logic [29:0] ePa;
  logic [31:0] eRd;
  string       eTag;
  int          vectors = 0;
  int          fails = 0;
  bit          done = 0;

  task automatic miss(string tag, string what, logic [31:0] act, logic [31:0] exp);
    fails++;
    $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
  endtask

  task automatic compareNow();
    vectors++;
    if (rspValid !== eRspV) miss(eTag, "rspValid", 32'(rspValid), 32'(eRspV));
    if (eRspV && rspHit !== eHit) miss(eTag, "rspHit", 32'(rspHit), 32'(eHit));
    if (eRspV && rspPa !== ePa) miss(eTag, "rspPa", 32'(rspPa), 32'(ePa));
    if (invMapErr !== eErr) miss(eTag, "invMapErr", 32'(invMapErr), 32'(eErr));
    if (regRvalid !== eRv) miss(eTag, "regRvalid", 32'(regRvalid), 32'(eRv));
    if (eRv && regRdata !== eRd) miss(eTag, "regRdata", regRdata, eRd);
  endtask

  task automatic clearExp(string tag);
    eRspV = 0; eHit = 0; eErr = 0; eRv = 0; ePa = '0; eRd = '0; eTag = tag;
  endtask

  // One cycle: check previous results, apply new stimulus, advance model.
  task automatic drive(string tag, bit lk, logic [16:0] va, bit rd, bit wr,
                       bit sel, logic [7:0] idx, logic [31:0] wd, bit init);
    logic [31:0] ent;
    @(negedge clk);
    compareNow();
    lkValid = lk; lkVa = va; regRd = rd; regWr = wr; regSel = sel;
    regIdx = idx; regWdata = wd; adapterInit = init;
    ent   = mapM[va[16:9]];
    eTag  = tag;
    eRspV = lk && !init;
    eHit  = ent[31];
    ePa   = ent[31] ? {ent[20:0], va[8:0]} : '0;
    eErr  = eRspV && !ent[31];
    eRv   = rd;
    eRd   = sel ? smrM : mapM[idx];
    if (init) smrM = '0;
    else if (lk) smrM = ent;
    if (wr && !sel) mapM[idx] = wd & KEEP;
  endtask

  task automatic idle(string tag);
    drive(tag, 0, '0, 0, 0, 0, '0, '0, 0);
  endtask
  task automatic mapWrite(string tag, logic [7:0] idx, logic [31:0] wd);
    drive(tag, 0, '0, 0, 1, 0, idx, wd, 0);
  endtask
  task automatic mapRead(string tag, logic [7:0] idx);
    drive(tag, 0, '0, 1, 0, 0, idx, '0, 0);
  endtask
  task automatic smrRead(string tag);
    drive(tag, 0, '0, 1, 0, 1, '0, '0, 0);
  endtask
  task automatic lookup(string tag, logic [16:0] va);
    drive(tag, 1, va, 0, 0, 0, '0, '0, 0);
  endtask

  task automatic doReset(string tag);
    @(negedge clk);
    compareNow();
    rstN = 0; lkValid = 0; regRd = 0; regWr = 0; adapterInit = 0;
    for (int e = 0; e < 256; e++) mapM[e] = '0;
    smrM = '0;
    clearExp(tag);
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      compareNow();
    end
    rstN = 1;
  endtask

  initial begin
    for (int e = 0; e < 256; e++) mapM[e] = '0;
    smrM = '0;
    clearExp("R1");
    #1;
    compareNow();                         // R1: outputs low in reset
    doReset("R1");
    idle("R1"); idle("R1");
    mapRead("R1", 8'd0); mapRead("R1", 8'd255); mapRead("R1", 8'd77);
    smrRead("R1"); idle("R1");

    // R2: only valid flag and frame number are kept
    mapWrite("R2", 8'd5, 32'hFFFF_FFFF);
    mapWrite("R2", 8'd6, 32'h7FE0_1234);
    mapRead("R2", 8'd5); mapRead("R2", 8'd6); idle("R2");

    // R3: hits
    mapWrite("R3", 8'd10, 32'h8000_0ABC);
    mapWrite("R3", 8'd255, 32'h801F_0000);
    lookup("R3", {8'd10, 9'h1FF});
    lookup("R3", 17'h1FFFF);
    lookup("R3", {8'd5, 9'h000});
    idle("R3");

    // R4: misses, including invalid entry with nonzero frame
    lookup("R4", {8'd6, 9'h0AA});
    smrRead("R5");
    lookup("R4", {8'd0, 9'h001});
    idle("R4");

    // R5: capture of the used entry; read same cycle sees earlier value
    lookup("R5", {8'd10, 9'h003});
    smrRead("R5");
    drive("R5", 1, {8'd255, 9'h010}, 1, 0, 1, '0, '0, 0);
    smrRead("R5"); idle("R5");

    // R6: lookup and write of the same entry in one cycle
    drive("R6", 1, {8'd20, 9'h044}, 0, 1, 0, 8'd20, 32'h8000_0055, 0);
    smrRead("R6");
    lookup("R6", {8'd20, 9'h044});
    idle("R6");

    // R7: read and write of the same entry in one cycle
    drive("R7", 0, '0, 1, 1, 0, 8'd21, 32'h8012_3456, 0);
    mapRead("R7", 8'd21); idle("R7");

    // R8: init clears the capture, drops a same-cycle lookup, keeps map
    lookup("R8", {8'd10, 9'h000});
    drive("R8", 1, {8'd6, 9'h000}, 0, 0, 0, '0, '0, 1);
    smrRead("R8"); mapRead("R8", 8'd10);
    lookup("R8", {8'd10, 9'h07F}); idle("R8");

    // R9: writes aimed at the capture register change nothing
    lookup("R9", {8'd10, 9'h000});
    drive("R9", 0, '0, 0, 1, 1, 8'd3, 32'hDEAD_BEEF, 0);
    smrRead("R9"); mapRead("R9", 8'd3); idle("R9");

    // R10: back-to-back lookups
    for (int i = 0; i < 16; i++)
      mapWrite("R10", 8'(100 + i), ((i % 3) != 0 ? 32'h8000_0000 : 32'h0) | 32'(i * 4099));
    for (int i = 0; i < 16; i++)
      lookup("R10", {8'(100 + i), 9'((i * 13) & 9'h1FF)});
    idle("R10");

    // R11: only power-up reset clears the map
    drive("R11", 0, '0, 0, 0, 0, '0, '0, 1);
    mapRead("R11", 8'd10);
    doReset("R11");
    idle("R11");
    mapRead("R11", 8'd10); mapRead("R11", 8'd255);
    lookup("R11", {8'd10, 9'h005});
    idle("R11"); idle("R11");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

endmodule